// File: doc/BRIEF.md
# Four-State Dynamic Branch Predictor

This block guesses, for each conditional branch, whether it will be taken. It keeps a small direct-mapped table addressed by low bits of the branch address. Each entry holds a valid bit and one of four confidence states: strongly taken, likely taken, likely not taken and strongly not taken. A combinational lookup port takes a branch address and its target and returns a taken/not-taken guess. A clocked update port takes the same pair with the resolved outcome and moves the entry's state.

The state machine is not a saturating counter. A taken outcome from likely-not-taken jumps straight to strongly taken. A taken outcome from strongly-not-taken climbs only to likely-not-taken. An entry that has never been written takes its starting confidence from a static direction hint. A branch that jumps backward (target below its own address) starts as likely taken. Any other branch starts as likely not taken. This makes the closing branch of a loop correct on its first pass.

Top module: `branch_predictor`

## Requirements
- R1: After reset every entry is empty, and a lookup returns the static hint: taken when the target is strictly below the branch address, not taken otherwise.
- R2: The lookup output is 1 (taken) when the entry's state is strongly or likely taken, and 0 when it is likely or strongly not taken. State encoding: 0 strongly not taken, 1 likely not taken, 2 likely taken, 3 strongly taken.
- R3: The first update of an empty entry starts from the hint state (likely taken for a backward branch, likely not taken otherwise), applies the outcome, and marks the entry valid.
- R4: Likely not taken with a taken outcome goes directly to strongly taken. Likely not taken with a not-taken outcome goes to strongly not taken.
- R5: Strongly taken with a not-taken outcome goes to likely taken. Likely taken goes to likely not taken on not taken and to strongly taken on taken. Strongly taken stays put on taken.
- R6: Strongly not taken with a taken outcome goes to likely not taken, so a second taken outcome is needed to reach strongly taken. Strongly not taken stays put on not taken.
- R7: A lookup to the same index as an update in the same cycle returns the prediction from before that update. The new state is visible from the next cycle.
- R8: The table index is address bits [7:2] (64 entries). There is no tag: addresses equal in those bits share one entry, and entries with other index values are unaffected.
- R9: For a backward loop-closing branch taken on every pass but the last, the block mispredicts only on the loop exit. On re-entry the first pass is predicted correctly.
- R10: With the update strobe low, the update address and outcome have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being predicted |
| lk_target | input | 32 | Target address of the branch being predicted |
| lk_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| up_valid | input | 1 | Update strobe |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Target address of the resolved branch |
| up_taken | input | 1 | Resolved outcome: 1 taken |

## Verification
A lookup and an update can fall in the same cycle on the same table index. The read is combinational and the write lands at the clock edge. The bench sets a likely-taken entry, then holds a lookup on that address while it presents a not-taken update in the same cycle. It expects the old taken guess before the edge and the not-taken guess after it. The same collision is provoked through an aliased address, so that the shared entry, not the address match, is what carries the effect.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BP_SNT = 2'd0,
    BP_LNT = 2'd1,
    BP_LT  = 2'd2,
    BP_ST  = 2'd3
  } bp_state_e;

  // asymmetric transition on a resolved outcome
  function automatic bp_state_e bp_next(input bp_state_e s, input logic taken);
    bp_state_e n;
    case (s)
      BP_SNT:  n = taken ? BP_LNT : BP_SNT;
      BP_LNT:  n = taken ? BP_ST  : BP_SNT;
      BP_LT:   n = taken ? BP_ST  : BP_LNT;
      default: n = taken ? BP_ST  : BP_LT;
    endcase
    return n;
  endfunction

  function automatic logic bp_predict(input bp_state_e s);
    return (s == BP_LT) || (s == BP_ST);
  endfunction

  function automatic bp_state_e bp_hint_state(input logic backward);
    return backward ? BP_LT : BP_LNT;
  endfunction

endpackage

// File: rtl/bp_hint.sv
module bp_hint #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  target,
  output logic             backward,
  output bp_pkg::bp_state_e init_state
);
  import bp_pkg::*;

  always_comb begin
    backward   = target < pc;
    init_state = bp_hint_state(backward);
  end

endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output bp_pkg::bp_state_e rd_state,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              cur_valid,
  output bp_pkg::bp_state_e cur_state,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  bp_pkg::bp_state_e wr_state
);
  import bp_pkg::*;

  logic      valid_q [ENTRIES];
  bp_state_e state_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        state_q[i] <= BP_LNT;
      end
    end else if (we) begin
      valid_q[wr_idx] <= 1'b1;
      state_q[wr_idx] <= wr_state;
    end
  end

  always_comb begin
    rd_valid  = valid_q[rd_idx];
    rd_state  = state_q[rd_idx];
    cur_valid = valid_q[cur_idx];
    cur_state = state_q[cur_idx];
  end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int ALIGN   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [PC_W-1:0] lk_target,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_taken
);
  import bp_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  // named internal events, observed by the bound checker
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             lk_back, up_back;
  bp_state_e        lk_hint, up_hint;
  logic             lk_valid, old_valid;
  bp_state_e        lk_state, old_state;
  bp_state_e        eff_lk_state, eff_old_state;
  logic             wr_en;
  bp_state_e        wr_state;

  assign lk_idx = lk_pc[ALIGN +: IDX_W];
  assign up_idx = up_pc[ALIGN +: IDX_W];

  bp_hint #(.PC_W(PC_W)) u_hint_lk (
    .pc(lk_pc), .target(lk_target), .backward(lk_back), .init_state(lk_hint)
  );

  bp_hint #(.PC_W(PC_W)) u_hint_up (
    .pc(up_pc), .target(up_target), .backward(up_back), .init_state(up_hint)
  );

  bp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_valid  (lk_valid),
    .rd_state  (lk_state),
    .cur_idx   (up_idx),
    .cur_valid (old_valid),
    .cur_state (old_state),
    .we        (wr_en),
    .wr_idx    (up_idx),
    .wr_state  (wr_state)
  );

  always_comb begin
    eff_lk_state  = lk_valid  ? lk_state  : lk_hint;
    eff_old_state = old_valid ? old_state : up_hint;
    wr_en         = up_valid;
    wr_state      = bp_next(eff_old_state, up_taken);
    lk_taken      = bp_predict(eff_lk_state);
  end

endmodule

// File: rtl/bp_checker.sv
module bp_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              old_valid,
  input logic              up_back,
  input logic              up_taken,
  input logic              up_valid,
  input bp_pkg::bp_state_e eff_old_state,
  input bp_pkg::bp_state_e wr_state,
  input logic [31:0]       lk_pc,
  input logic [31:0]       lk_target,
  input logic              lk_taken
);
  import bp_pkg::*;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_lnt_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && eff_old_state == BP_LNT && up_taken) |-> wr_state == BP_ST);

  assert_st_nt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && eff_old_state == BP_ST && !up_taken) |-> wr_state == BP_LT);

  assert_snt_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && eff_old_state == BP_SNT && up_taken) |-> wr_state == BP_LNT);

  assert_alloc_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && !old_valid && up_back && up_taken) |-> wr_state == BP_ST);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !up_valid) ##1 ($stable(lk_pc) && $stable(lk_target)) |-> $stable(lk_taken));

endmodule

bind branch_predictor bp_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .old_valid     (old_valid),
  .up_back       (up_back),
  .up_taken      (up_taken),
  .up_valid      (up_valid),
  .eff_old_state (eff_old_state),
  .wr_state      (wr_state),
  .lk_pc         (lk_pc),
  .lk_target     (lk_target),
  .lk_taken      (lk_taken)
);

// File: tb/branch_predictor_tb.sv
module branch_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0, lk_target = '0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0, up_target = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  branch_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_target(lk_target), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken)
  );

  task automatic check(input string req, input logic [31:0] pc, input logic [31:0] tgt,
                       input logic exp);
    lk_pc = pc; lk_target = tgt;
    #1;
    checks++;
    if (lk_taken !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, lk_taken, exp);
    end
  endtask

  // drives at a falling edge, write lands at the next rising edge
  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input logic t);
    up_pc = pc; up_target = tgt; up_taken = t; up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 32'h100, 32'h080, 1'b1);
    check("R1", 32'h104, 32'h200, 1'b0);
    check("R1", 32'h104, 32'h104, 1'b0);
  endtask

  task automatic t_chain();
    logic [31:0] a = 32'h208, t = 32'h300;
    check("R2", a, t, 1'b0);
    upd(a, t, 1'b1); check("R4", a, t, 1'b1);   // LNT -> ST
    upd(a, t, 1'b1); check("R5", a, t, 1'b1);   // ST stays
    upd(a, t, 1'b0); check("R5", a, t, 1'b1);   // ST -> LT
    upd(a, t, 1'b0); check("R5", a, t, 1'b0);   // LT -> LNT
    upd(a, t, 1'b0); check("R4", a, t, 1'b0);   // LNT -> SNT
    upd(a, t, 1'b0); check("R6", a, t, 1'b0);   // SNT stays
    upd(a, t, 1'b1); check("R6", a, t, 1'b0);   // SNT -> LNT
    upd(a, t, 1'b1); check("R6", a, t, 1'b1);   // LNT -> ST
    upd(a, t, 1'b0); upd(a, t, 1'b1);           // ST -> LT -> ST
    upd(a, t, 1'b0); check("R5", a, t, 1'b1);   // back at LT
  endtask

  task automatic t_alloc();
    upd(32'h10C, 32'h000, 1'b0); check("R3", 32'h10C, 32'h000, 1'b0); // LT -> LNT
    upd(32'h110, 32'h400, 1'b0);                                      // LNT -> SNT
    upd(32'h110, 32'h400, 1'b1); check("R3", 32'h110, 32'h400, 1'b0); // SNT -> LNT
    upd(32'h110, 32'h400, 1'b1); check("R3", 32'h110, 32'h400, 1'b1);
  endtask

  task automatic t_collide();
    logic [31:0] a = 32'h114, t = 32'h010;
    upd(a, t, 1'b1); upd(a, t, 1'b0);           // ST then LT
    up_pc = a; up_target = t; up_taken = 1'b0; up_valid = 1'b1;
    check("R7", a, t, 1'b1);                    // same cycle: old guess
    @(negedge clk); up_valid = 1'b0;
    check("R7", a, t, 1'b0);                    // now LNT
  endtask

  task automatic t_alias();
    upd(32'h218, 32'h600, 1'b1);                // idx 6 -> ST
    check("R8", 32'h118, 32'h600, 1'b1);
    check("R8", 32'h11C, 32'h600, 1'b0);        // idx 7 untouched
    // aliased collision: LT entry, update through one alias, look up via the other
    upd(32'h118, 32'h600, 1'b0);                // ST -> LT
    up_pc = 32'h218; up_target = 32'h600; up_taken = 1'b0; up_valid = 1'b1;
    check("R7", 32'h118, 32'h600, 1'b1);
    @(negedge clk); up_valid = 1'b0;
    check("R7", 32'h118, 32'h600, 1'b0);
  endtask

  task automatic t_idle();
    upd(32'h120, 32'h500, 1'b0);                // LNT -> SNT
    up_pc = 32'h120; up_target = 32'h500; up_taken = 1'b1; up_valid = 1'b0;
    repeat (3) @(negedge clk);
    upd(32'h120, 32'h500, 1'b1);                // SNT -> LNT only if idle had no effect
    check("R10", 32'h120, 32'h500, 1'b0);
  endtask

  task automatic t_loop();
    logic [31:0] a = 32'h124, t = 32'h0F0;
    for (int run = 0; run < 2; run++) begin
      int miss = 0;
      int first_miss = 0;
      for (int pass = 0; pass < 5; pass++) begin
        logic outcome = (pass != 4);
        lk_pc = a; lk_target = t; #1;
        if (lk_taken !== outcome) begin
          miss++;
          if (pass == 0) first_miss = 1;
        end
        upd(a, t, outcome);
      end
      checks++;
      if (miss != 1) begin
        errors++;
        $display("FAIL R9 run %0d mispredicts actual=%0d expected=1", run, miss);
      end
      checks++;
      if (first_miss != 0) begin
        errors++;
        $display("FAIL R9 run %0d first-pass miss actual=%0d expected=0", run, first_miss);
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_alloc();
    t_collide();
    t_alias();
    t_idle();
    t_loop();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule